// File: doc/BRIEF.md
# Machine-Cycle Timer/Counter with Level Gate

This block is a 16-bit up-counter driven by a fast system clock that is split into machine cycles of twelve clocks each. In timer mode it adds one at the end of every machine cycle, so it measures elapsed time in machine-cycle units. In edge mode it counts falling edges on an external count pin. The pin is looked at only once per machine cycle, at a fixed phase. An edge is recognised when one look sees a high level and the next look sees a low level.

Counting is enabled by a run input. When the gate enable input is set, counting is also qualified by an external gate pin. That pin is sampled at the same phase as the count pin. With timer mode and the gate enabled, the count after a high pulse on the gate pin equals the pulse width in machine cycles. A synchronous load port can overwrite the count on any clock, and it takes priority over an increment on that clock. When the count wraps from all ones to zero, the block raises a one-clock overflow pulse.

Top module: `mcyc_timer`

## Requirements
- R1: While reset is asserted (active-low, synchronous), the count output is 0 and the overflow output is 0. The machine-cycle phase restarts at 0 on the first clock after reset is released.
- R2: With run=1, edge select=0 and gate enable=0, the count rises by exactly one per 12 clocks. The new value appears on the clock that begins a machine cycle (phase 0).
- R3: With edge select=1, the count pin is sampled once per machine cycle at phase 9. An increment is earned only when the previous sample was 1 and the current sample is 0. The sample history is 0 after reset. A pin pulse that does not cover a sampling phase, or a pin held at a constant level, earns nothing.
- R4: In edge mode, the increment earned by a 0 sample becomes visible at phase 0 of the next machine cycle. That is the third machine cycle counting from the cycle that sampled the 1.
- R5: With run=0, neither machine cycles nor pin edges change the count.
- R6: With gate enable=1, a machine cycle may increment only if the gate pin was sampled high at phase 9 of that cycle, in both modes. With gate enable=0, the gate pin has no effect.
- R7: A load strobe writes the load value into the count on the next clock edge, on any phase. If an increment falls on the same edge, the loaded value wins.
- R8: An increment from 16'hFFFF gives 16'h0000. The overflow output is 1 for exactly the one clock in which that 0 first appears.
- R9: Apart from loads, the count changes only on the edge that ends a machine cycle (phase 11 to 0), and by at most one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 12 per machine cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | Enables counting when 1 |
| sel_edge_i | input | 1 | 1 = count pin falling edges, 0 = count machine cycles |
| gate_en_i | input | 1 | 1 = qualify counting with the gate pin |
| cnt_pin_i | input | 1 | External count pin |
| gate_pin_i | input | 1 | External gate pin (active high) |
| load_i | input | 1 | Synchronous load strobe |
| load_val_i | input | 16 | Value written by a load |
| count_o | output | 16 | Current count |
| ovf_o | output | 1 | One-clock pulse on wrap to zero |

## Verification
Timer mode is run both free and under a gate pulse of known width. Only the free run can tell a per-clock increment from a per-machine-cycle one, and only the gated run shows whether the gate sample lines up with the right cycle. In edge mode the pin is driven with long pulses that straddle the sampling phase, with short pulses that fall between two samples, and with constant levels. These patterns separate true sampled-edge detection from level counting and from detection on every clock. A single directed edge pins the two-cycle visibility latency. Loads are placed on the cycle-ending clock, and a load of all ones is followed by a wrap. Seeded random control and pin activity is then compared clock by clock against a bench model.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

   typedef enum logic {
      MODE_CYCLES = 1'b0,
      MODE_EDGES  = 1'b1
   } cnt_mode_e;

   localparam int unsigned PIN_COUNT = 0;
   localparam int unsigned PIN_GATE  = 1;
   localparam int unsigned PIN_NUM   = 2;

endpackage

// File: rtl/mcyc_phase_gen.sv
module mcyc_phase_gen #(
   parameter int unsigned CYC_LEN   = 12,
   parameter int unsigned SAMPLE_PH = 9,
   parameter int unsigned PH_W      = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [PH_W-1:0] phase_o,
   output logic            smp_stb_o,
   output logic            end_stb_o
);

   localparam logic [PH_W-1:0] LAST_PH = PH_W'(CYC_LEN - 1);
   localparam logic [PH_W-1:0] SMP_PH  = PH_W'(SAMPLE_PH);

   logic [PH_W-1:0] phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (phase_q == LAST_PH) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + PH_W'(1);
      end
   end

   assign phase_o   = phase_q;
   assign smp_stb_o = (phase_q == SMP_PH);
   assign end_stb_o = (phase_q == LAST_PH);

endmodule

// File: rtl/mcyc_pin_sampler.sv
module mcyc_pin_sampler
   import mcyc_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic smp_stb_i,
   input  logic cnt_pin_i,
   input  logic gate_pin_i,
   output logic fall_pend_o,
   output logic gate_smp_o
);

   logic [PIN_NUM-1:0] raw;
   logic [PIN_NUM-1:0] pins;

   assign raw[PIN_COUNT] = cnt_pin_i;
   assign raw[PIN_GATE]  = gate_pin_i;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign pins = raw;
      end else begin : g_sync
         logic [PIN_NUM-1:0] chain [SYNC_STAGES];
         for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  chain[s] <= '0;
               end else if (s == 0) begin
                  chain[s] <= raw;
               end else begin
                  chain[s] <= chain[(s == 0) ? 0 : s-1];
               end
            end
         end
         assign pins = chain[SYNC_STAGES-1];
      end
   endgenerate

   logic cnt_smp_q;
   logic fall_q;
   logic gate_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_smp_q <= 1'b0;
         fall_q    <= 1'b0;
         gate_q    <= 1'b0;
      end else if (smp_stb_i) begin
         cnt_smp_q <= pins[PIN_COUNT];
         fall_q    <= cnt_smp_q & ~pins[PIN_COUNT];
         gate_q    <= pins[PIN_GATE];
      end
   end

   assign fall_pend_o = fall_q;
   assign gate_smp_o  = gate_q;

endmodule

// File: rtl/mcyc_count_reg.sv
module mcyc_count_reg #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic [CNT_W-1:0] count_o,
   output logic             ovf_o
);

   localparam logic [CNT_W-1:0] ALL_ONES = '1;

   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
         ovf_q <= 1'b0;
      end else if (inc_i) begin
         cnt_q <= cnt_q + CNT_W'(1);
         ovf_q <= (cnt_q == ALL_ONES);
      end else begin
         ovf_q <= 1'b0;
      end
   end

   assign count_o = cnt_q;
   assign ovf_o   = ovf_q;

endmodule

// File: rtl/mcyc_timer.sv
module mcyc_timer
   import mcyc_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned CYC_LEN     = 12,
   parameter int unsigned SAMPLE_PH   = 9,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             sel_edge_i,
   input  logic             gate_en_i,
   input  logic             cnt_pin_i,
   input  logic             gate_pin_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic [CNT_W-1:0] count_o,
   output logic             ovf_o
);

   localparam int unsigned PH_W = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("mcyc_timer: CNT_W must be at least 2");
      end
      if (CYC_LEN < 3) begin : g_bad_len
         $error("mcyc_timer: CYC_LEN must be at least 3");
      end
      if (SAMPLE_PH >= CYC_LEN - 1) begin : g_bad_phase
         $error("mcyc_timer: SAMPLE_PH must precede the last phase");
      end
   endgenerate

   logic [PH_W-1:0] phase;
   logic            smp_stb;
   logic            end_stb;
   logic            fall_pend;
   logic            gate_smp;
   logic            gate_ok;
   logic            event_ok;
   logic            inc;
   cnt_mode_e       mode;

   assign mode = cnt_mode_e'(sel_edge_i);

   mcyc_phase_gen #(
      .CYC_LEN   (CYC_LEN),
      .SAMPLE_PH (SAMPLE_PH),
      .PH_W      (PH_W)
   ) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .phase_o   (phase),
      .smp_stb_o (smp_stb),
      .end_stb_o (end_stb)
   );

   mcyc_pin_sampler #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sampler (
      .clk         (clk),
      .rst_n       (rst_n),
      .smp_stb_i   (smp_stb),
      .cnt_pin_i   (cnt_pin_i),
      .gate_pin_i  (gate_pin_i),
      .fall_pend_o (fall_pend),
      .gate_smp_o  (gate_smp)
   );

   assign gate_ok  = ~gate_en_i | gate_smp;
   assign event_ok = (mode == MODE_EDGES) ? fall_pend : 1'b1;
   assign inc      = end_stb & run_i & gate_ok & event_ok;

   mcyc_count_reg #(
      .CNT_W (CNT_W)
   ) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .inc_i      (inc),
      .load_i     (load_i),
      .load_val_i (load_val_i),
      .count_o    (count_o),
      .ovf_o      (ovf_o)
   );

endmodule

// File: rtl/mcyc_timer_chk.sv
module mcyc_timer_chk #(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned CYC_LEN = 12,
   parameter int unsigned PH_W    = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_i,
   input logic             gate_en_i,
   input logic             load_i,
   input logic [CNT_W-1:0] load_val_i,
   input logic [CNT_W-1:0] count_o,
   input logic             ovf_o,
   input logic [PH_W-1:0]  phase,
   input logic             gate_smp
);

   localparam logic [PH_W-1:0]  LAST_PH  = PH_W'(CYC_LEN - 1);
   localparam logic [CNT_W-1:0] ALL_ONES = '1;
   localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

   AST_HOLD_MIDCYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && phase != LAST_PH) |=> $stable(count_o)); // R9

   AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> (count_o == $past(count_o) || count_o == $past(count_o) + ONE)); // R2

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (count_o == $past(load_val_i))); // R7

   AST_RUN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !load_i) |=> $stable(count_o)); // R5

   AST_GATE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_en_i && !gate_smp && !load_i) |=> $stable(count_o)); // R6

   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> (count_o == '0)); // R8

   AST_WRAP_FROM_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && count_o == ALL_ONES && phase == LAST_PH && $past(rst_n)) |=>
      (ovf_o || count_o == ALL_ONES)); // R8

   AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> !ovf_o); // R8

endmodule

bind mcyc_timer mcyc_timer_chk #(
   .CNT_W   (CNT_W),
   .CYC_LEN (CYC_LEN),
   .PH_W    (PH_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .run_i      (run_i),
   .gate_en_i  (gate_en_i),
   .load_i     (load_i),
   .load_val_i (load_val_i),
   .count_o    (count_o),
   .ovf_o      (ovf_o),
   .phase      (phase),
   .gate_smp   (gate_smp)
);

// File: tb/mcyc_timer_bench.sv
module mcyc_timer_bench;

   localparam int CLK_P = 10;
   localparam int CW    = 16;
   localparam int CYC   = 12;
   localparam int SMP   = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run_i = 1'b0;
   logic          sel_edge_i = 1'b0;
   logic          gate_en_i = 1'b0;
   logic          cnt_pin_i = 1'b0;
   logic          gate_pin_i = 1'b0;
   logic          load_i = 1'b0;
   logic [CW-1:0] load_val_i = '0;
   logic [CW-1:0] count_o;
   logic          ovf_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   bit cmp_on = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   mcyc_timer u_mcyc_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (run_i),
      .sel_edge_i (sel_edge_i),
      .gate_en_i  (gate_en_i),
      .cnt_pin_i  (cnt_pin_i),
      .gate_pin_i (gate_pin_i),
      .load_i     (load_i),
      .load_val_i (load_val_i),
      .count_o    (count_o),
      .ovf_o      (ovf_o)
   );

   // Bench reference model, written from the requirements
   int            m_ph;
   logic          m_smp, m_fall, m_gate, m_ovf;
   logic [CW-1:0] m_cnt;

   function automatic bit earns_step(input bit run, input bit edge_mode, input bit gen,
                                     input bit gsmp, input bit fall);
      if (!run) return 1'b0;
      if (gen && !gsmp) return 1'b0;
      if (edge_mode) return fall;
      return 1'b1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph <= 0; m_smp <= 0; m_fall <= 0; m_gate <= 0; m_cnt <= '0; m_ovf <= 0;
      end else begin
         m_ph <= (m_ph == CYC-1) ? 0 : m_ph + 1;
         if (m_ph == SMP) begin
            m_smp  <= cnt_pin_i;
            m_fall <= m_smp & ~cnt_pin_i;
            m_gate <= gate_pin_i;
         end
         m_ovf <= 1'b0;
         if (load_i) m_cnt <= load_val_i;
         else if (m_ph == CYC-1 && earns_step(run_i, sel_edge_i, gate_en_i, m_gate, m_fall)) begin
            m_cnt <= m_cnt + 16'd1;
            m_ovf <= (m_cnt == 16'hFFFF);
         end
      end
   end

   task automatic check(input string req, input logic [CW-1:0] got, input logic [CW-1:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on && !done) begin
         check("R9 model count", count_o, m_cnt);
         check("R8 model ovf", {15'd0, ovf_o}, {15'd0, m_ovf});
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_ph(input int p);
      do @(negedge clk); while (m_ph != p);
   endtask

   task automatic do_load(input logic [CW-1:0] v);
      load_i = 1'b1; load_val_i = v;
      tick(1);
      load_i = 1'b0;
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         wait_ph(0); cnt_pin_i = 1'b1;
         tick(CYC);  cnt_pin_i = 1'b0;
         tick(CYC - 1);
      end
      tick(2 * CYC);
   endtask

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         n_bad++; n_cmp++;
         $display("FAIL watchdog: got running expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // R1 reset
      tick(3);
      check("R1 count in reset", count_o, 16'h0000);
      check("R1 ovf in reset", {15'd0, ovf_o}, 16'h0000);
      rst_n = 1'b1;

      // R5 run off
      tick(5 * CYC);
      check("R5 run=0 holds", count_o, 16'h0000);

      // R2 timer mode, visible at phase 0
      wait_ph(11); run_i = 1'b1;
      check("R2 before end", count_o, 16'h0000);
      tick(1);
      check("R2 at phase 0", count_o, 16'h0001);
      tick(11);
      check("R9 held through cycle", count_o, 16'h0001);
      tick(1 + 10 * CYC);
      check("R2 eleven cycles", count_o, 16'd12);

      // R7 load beats increment on cycle end
      wait_ph(11); do_load(16'h1234);
      check("R7 load priority", count_o, 16'h1234);
      tick(CYC);
      check("R7 counts after load", count_o, 16'h1235);

      // R8 wrap
      wait_ph(5); do_load(16'hFFFF);
      wait_ph(11);
      check("R8 max before wrap", count_o, 16'hFFFF);
      check("R8 no ovf early", {15'd0, ovf_o}, 16'h0000);
      tick(1);
      check("R8 wrapped", count_o, 16'h0000);
      check("R8 ovf pulse", {15'd0, ovf_o}, 16'h0001);
      tick(1);
      check("R8 ovf single", {15'd0, ovf_o}, 16'h0000);

      // R6 gate in timer mode
      wait_ph(0); gate_en_i = 1'b1; gate_pin_i = 1'b0; do_load(16'h0000);
      tick(5 * CYC);
      check("R6 gate low blocks", count_o, 16'h0000);
      wait_ph(0); gate_pin_i = 1'b1;
      tick(7 * CYC); gate_pin_i = 1'b0;
      tick(3 * CYC);
      check("R6 pulse width 7", count_o, 16'd7);
      wait_ph(0); gate_en_i = 1'b0;
      tick(4 * CYC);
      check("R6 gate ignored when off", count_o, 16'd11);

      // R3/R4 edge mode latency
      sel_edge_i = 1'b1; cnt_pin_i = 1'b0;
      tick(2 * CYC); wait_ph(3); do_load(16'h0000);
      wait_ph(SMP); cnt_pin_i = 1'b1;
      wait_ph(SMP); cnt_pin_i = 1'b0;
      tick(2);
      check("R4 not yet at phase 11", count_o, 16'h0000);
      tick(1);
      check("R4 visible at phase 0", count_o, 16'h0001);

      // R3 short pulse between samples
      wait_ph(1); cnt_pin_i = 1'b1;
      wait_ph(6); cnt_pin_i = 1'b0;
      tick(3 * CYC);
      check("R3 short pulse ignored", count_o, 16'h0001);
      cnt_pin_i = 1'b1; tick(4 * CYC);
      check("R3 steady high no count", count_o, 16'h0001);
      cnt_pin_i = 1'b0; tick(3 * CYC);
      check("R3 single fall", count_o, 16'h0002);

      pulses(5);
      check("R3 five edges", count_o, 16'd7);
      run_i = 1'b0; pulses(3);
      check("R5 edges with run off", count_o, 16'd7);
      run_i = 1'b1; gate_en_i = 1'b1; gate_pin_i = 1'b0; pulses(3);
      check("R6 edges gated off", count_o, 16'd7);
      gate_pin_i = 1'b1; pulses(2);
      check("R6 edges gated on", count_o, 16'd9);

      // Random phase against model
      void'($urandom(32'h5EED_1234));
      cmp_on = 1'b1;
      for (int c = 0; c < 400; c++) begin
         wait_ph(0);
         run_i      = ($urandom % 8) != 0;
         sel_edge_i = $urandom % 2;
         gate_en_i  = ($urandom % 3) == 0;
         gate_pin_i = ($urandom % 4) != 0;
         for (int k = 0; k < CYC - 1; k++) begin
            if (($urandom % 5) == 0) cnt_pin_i = ~cnt_pin_i;
            if (($urandom % 4) == 0) gate_pin_i = ~gate_pin_i;
            if (($urandom % 40) == 0) begin
               load_i = 1'b1;
               load_val_i = (($urandom % 2) == 0) ? 16'hFFFE : 16'($urandom);
            end else begin
               load_i = 1'b0;
            end
            tick(1);
         end
         load_i = 1'b0;
      end
      tick(2);
      cmp_on = 1'b0;
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule